// File: doc/BRIEF.md
# Multi-Level Priority Cell Slot Scheduler

This block decides, once per cell slot, which transmit channel may send the next cell. Each channel is placed, by an insert command, into one of several priority levels. Every level keeps its own table of member channels. On a slot tick, the scheduler checks the most urgent level first and falls through to less urgent levels until it finds a channel that is ready. Within a level, ready channels take turns. If no channel anywhere is ready, the slot is marked idle so that an idle cell can be sent in its place.

Each channel is paced by a cell interval, given in slots. A channel can also be flagged as minimum-rate-guaranteed. Such a channel carries two intervals: a short one for its peak rate and a long one for its minimum rate. The block counts how many slots the channel spent ready but unserved before its grant. If that wait exceeded a programmable maximum-delay threshold, the next cell is paced at the minimum rate. Otherwise the next cell is paced at the peak rate. Cell payloads, adaptation layers and memory-resident tables are handled elsewhere.

Top module: `cell_slot_sched`

## Requirements
- R1: After synchronous reset, grant_valid, grant_idle and ins_err are 0, and no channel is a member of any level.
- R2: An insert (ins_valid high for one cycle) is accepted when the channel is not yet a member of any level, the level index is below NUM_LVL, and that level holds fewer than TBL_DEPTH entries. An accepted channel joins its level behind the entries already there, and ins_err stays 0 in the cycle after the insert.
- R3: An insert into a level that already holds TBL_DEPTH entries, or an insert of a channel that is already a member, is rejected. In that case ins_err is 1 for exactly the cycle after the insert, and no table or channel state changes.
- R4: grant_valid is 1 in exactly the cycle after each slot_tick cycle, and 0 in every other cycle.
- R5: Level 0 is the most urgent level and level NUM_LVL-1 the least urgent. A grant always comes from the lowest-numbered level that holds a ready channel, and grant_level reports that level.
- R6: Within a level, the search for a ready channel starts at the entry after the one last granted in that level and wraps around. Entries are ordered by insertion. The first search of a level starts at its first entry.
- R7: When no channel is ready at a slot tick, the grant for that slot has grant_idle = 1, grant_chan = 0 and grant_level = 0.
- R8: A channel is ready at a slot tick when it is a member, its pacing gap has expired, and its cell_pend bit is 1.
- R9: After a grant that uses interval N, the channel's next possible grant is N slot ticks later. An interval of 0 acts as 1.
- R10: A channel's delay counts the slot ticks in which it was ready but not granted. The count clears when the channel is granted.
- R11: At a grant of a minimum-rate-flagged channel, the minimum-rate interval applies if the delay is strictly greater than max_delay; otherwise the peak-rate interval applies. A channel without the flag always uses its peak-rate interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert command strobe |
| ins_chan | input | CH_W | Channel number to insert |
| ins_level | input | LVL_W | Priority level, 0 most urgent |
| ins_pcr_int | input | INT_W | Peak-rate cell interval in slots |
| ins_mcr_int | input | INT_W | Minimum-rate cell interval in slots |
| ins_min_rate | input | 1 | Channel uses delay-based rate switching |
| max_delay | input | DLY_W | Maximum delay threshold in slots |
| cell_pend | input | NUM_CH | Per-channel cell waiting indication |
| slot_tick | input | 1 | One-cycle cell slot strobe |
| grant_valid | output | 1 | Grant result present |
| grant_idle | output | 1 | No channel ready in this slot |
| grant_chan | output | CH_W | Granted channel |
| grant_level | output | LVL_W | Level of granted channel |
| ins_err | output | 1 | Insert rejected |

## Verification
Some rules are checked by assertions on every cycle. These are: grants come only in the cycle after a tick, no more urgent level held a ready channel when a grant was made, an idle slot had no ready channel at all, a granted channel was ready and had a cell pending, table occupancy stays in bounds, and rejection pulses follow an insert. Other behaviour can only be shown by the bench's scenarios. This covers the round-robin order inside a level, the exact gap of idle slots that a pacing interval produces, the choice between peak and minimum interval at and around the delay threshold, and the fact that a rejected insert leaves the channel out of every table.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CS_MAX_LEVELS = 8;

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cs_level_table.sv
module cs_level_table #(
  parameter int DEPTH  = 16,
  parameter int NUM_CH = 32,
  parameter int CH_W   = cs_pkg::width_of(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [NUM_CH-1:0] ready,
  input  logic              adv,
  output logic              full,
  output logic              found,
  output logic [CH_W-1:0]   sel_chan
);
  localparam int IDX_W = cs_pkg::width_of(DEPTH);

  logic [CH_W-1:0]  tbl [DEPTH];
  logic [IDX_W:0]   cnt;
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] sel_idx;

  assign full = (cnt == (IDX_W+1)'(DEPTH));

  // entry storage: plain write port, no reset
  always_ff @(posedge clk) begin
    if (wr_en && !full) tbl[cnt[IDX_W-1:0]] <= wr_chan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      rr_ptr <= IDX_W'(DEPTH - 1);
    end else begin
      if (wr_en && !full) cnt <= cnt + 1'b1;
      if (adv && found) rr_ptr <= sel_idx;
    end
  end

  // round-robin search starting one past the last granted entry
  always_comb begin
    int unsigned w;
    found    = 1'b0;
    sel_idx  = rr_ptr;
    sel_chan = '0;
    for (int k = 1; k <= DEPTH; k++) begin
      w = (int'(rr_ptr) + k) % DEPTH;
      if (!found && (w < int'(cnt)) && ready[tbl[IDX_W'(w)]]) begin
        found    = 1'b1;
        sel_idx  = IDX_W'(w);
        sel_chan = tbl[IDX_W'(w)];
      end
    end
  end

  AST_TBL_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= (IDX_W+1)'(DEPTH)); // R3

  AST_ADV_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    adv |-> found); // R5
endmodule

// File: rtl/cs_chan_pacer.sv
module cs_chan_pacer #(
  parameter int INT_W = 6,
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [INT_W-1:0] pcr_int,
  input  logic [INT_W-1:0] mcr_int,
  input  logic             min_rate,
  input  logic [DLY_W-1:0] max_delay,
  input  logic             pend,
  input  logic             tick,
  input  logic             grant_me,
  output logic             ready
);
  logic             active;
  logic             min_q;
  logic [INT_W-1:0] pcr_q, mcr_q, pace_cnt;
  logic [DLY_W-1:0] dly_cnt;
  logic [INT_W-1:0] next_int, next_gap;

  assign ready    = active && (pace_cnt == '0) && pend;
  assign next_int = (min_q && (dly_cnt > max_delay)) ? mcr_q : pcr_q;
  assign next_gap = (next_int == '0) ? '0 : next_int - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      min_q    <= 1'b0;
      pcr_q    <= '0;
      mcr_q    <= '0;
      pace_cnt <= '0;
      dly_cnt  <= '0;
    end else if (load) begin
      active   <= 1'b1;
      min_q    <= min_rate;
      pcr_q    <= pcr_int;
      mcr_q    <= mcr_int;
      pace_cnt <= '0;
      dly_cnt  <= '0;
    end else if (tick) begin
      if (grant_me) begin
        pace_cnt <= next_gap;
        dly_cnt  <= '0;
      end else begin
        if (pace_cnt != '0) pace_cnt <= pace_cnt - 1'b1;
        if (ready && (dly_cnt != '1)) dly_cnt <= dly_cnt + 1'b1;
      end
    end
  end

  AST_GRANT_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
    tick && grant_me |-> ready); // R8

  AST_DELAY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    tick && grant_me && !load |=> dly_cnt == '0); // R10
endmodule

// File: rtl/cell_slot_sched.sv
module cell_slot_sched #(
  parameter int NUM_CH    = 32,
  parameter int NUM_LVL   = cs_pkg::CS_MAX_LEVELS,
  parameter int TBL_DEPTH = 16,
  parameter int INT_W     = 6,
  parameter int DLY_W     = 6,
  localparam int CH_W     = cs_pkg::width_of(NUM_CH),
  localparam int LVL_W    = cs_pkg::width_of(NUM_LVL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [CH_W-1:0]   ins_chan,
  input  logic [LVL_W-1:0]  ins_level,
  input  logic [INT_W-1:0]  ins_pcr_int,
  input  logic [INT_W-1:0]  ins_mcr_int,
  input  logic              ins_min_rate,
  input  logic [DLY_W-1:0]  max_delay,
  input  logic [NUM_CH-1:0] cell_pend,
  input  logic              slot_tick,
  output logic              grant_valid,
  output logic              grant_idle,
  output logic [CH_W-1:0]   grant_chan,
  output logic [LVL_W-1:0]  grant_level,
  output logic              ins_err
);
  logic [NUM_CH-1:0]             chan_active;
  logic [NUM_CH-1:0]             ready_vec;
  logic [NUM_LVL-1:0]            lvl_full, lvl_found, lvl_adv;
  logic [NUM_LVL-1:0][CH_W-1:0]  lvl_chan;
  logic                          accept, lvl_ok;
  logic                          win_found;
  logic [CH_W-1:0]               win_chan;
  logic [LVL_W-1:0]              win_lvl;

  assign lvl_ok = ({1'b0, ins_level} < (LVL_W+1)'(NUM_LVL));
  assign accept = ins_valid && lvl_ok && !chan_active[ins_chan] && !lvl_full[ins_level];

  // fall through levels, most urgent first
  always_comb begin
    win_found = 1'b0;
    win_chan  = '0;
    win_lvl   = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (!win_found && lvl_found[l]) begin
        win_found = 1'b1;
        win_chan  = lvl_chan[l];
        win_lvl   = LVL_W'(l);
      end
    end
  end

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    assign lvl_adv[l] = slot_tick && win_found && (win_lvl == LVL_W'(l));
    cs_level_table #(.DEPTH(TBL_DEPTH), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_tbl (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (accept && (ins_level == LVL_W'(l))),
      .wr_chan  (ins_chan),
      .ready    (ready_vec),
      .adv      (lvl_adv[l]),
      .full     (lvl_full[l]),
      .found    (lvl_found[l]),
      .sel_chan (lvl_chan[l])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cs_chan_pacer #(.INT_W(INT_W), .DLY_W(DLY_W)) u_pace (
      .clk       (clk),
      .rst       (rst),
      .load      (accept && (ins_chan == CH_W'(c))),
      .pcr_int   (ins_pcr_int),
      .mcr_int   (ins_mcr_int),
      .min_rate  (ins_min_rate),
      .max_delay (max_delay),
      .pend      (cell_pend[c]),
      .tick      (slot_tick),
      .grant_me  (win_found && (win_chan == CH_W'(c))),
      .ready     (ready_vec[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_active <= '0;
      grant_valid <= 1'b0;
      grant_idle  <= 1'b0;
      grant_chan  <= '0;
      grant_level <= '0;
      ins_err     <= 1'b0;
    end else begin
      if (accept) chan_active[ins_chan] <= 1'b1;
      ins_err     <= ins_valid && !accept;
      grant_valid <= slot_tick;
      if (slot_tick) begin
        grant_idle  <= !win_found;
        grant_chan  <= win_found ? win_chan : '0;
        grant_level <= win_found ? win_lvl  : '0;
      end
    end
  end

  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> $past(slot_tick)); // R4

  AST_NO_URGENT_SKIPPED: assert property (@(posedge clk) disable iff (rst)
    grant_valid && !grant_idle |->
      (($past(lvl_found) & ((NUM_LVL'(1) << grant_level) - NUM_LVL'(1))) == '0)); // R5

  AST_IDLE_MEANS_NONE: assert property (@(posedge clk) disable iff (rst)
    grant_valid && grant_idle |-> ($past(ready_vec) == '0)); // R7

  AST_GRANT_HAD_CELL: assert property (@(posedge clk) disable iff (rst)
    grant_valid && !grant_idle |-> ((($past(cell_pend) >> grant_chan) & NUM_CH'(1)) != '0)); // R8

  AST_ERR_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    ins_err |-> $past(ins_valid)); // R3
endmodule

// File: tb/cell_slot_sched_test.sv
module cell_slot_sched_test;
  localparam int NUM_CH = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic        ins_valid;
  logic [4:0]  ins_chan;
  logic [2:0]  ins_level;
  logic [5:0]  ins_pcr_int, ins_mcr_int;
  logic        ins_min_rate;
  logic [5:0]  max_delay;
  logic [31:0] cell_pend;
  logic        slot_tick;
  logic        grant_valid, grant_idle, ins_err;
  logic [4:0]  grant_chan;
  logic [2:0]  grant_level;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cell_slot_sched uut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_chan(ins_chan),
    .ins_level(ins_level), .ins_pcr_int(ins_pcr_int), .ins_mcr_int(ins_mcr_int),
    .ins_min_rate(ins_min_rate), .max_delay(max_delay), .cell_pend(cell_pend),
    .slot_tick(slot_tick), .grant_valid(grant_valid), .grant_idle(grant_idle),
    .grant_chan(grant_chan), .grant_level(grant_level), .ins_err(ins_err)
  );

  // {pend mask, expected idle, expected channel, expected level}
  localparam logic [40:0] VECS [9] = '{
    {32'h0000_00E8, 1'b0, 5'd3, 3'd0},
    {32'h0000_00E8, 1'b0, 5'd3, 3'd0},
    {32'h0000_00E0, 1'b0, 5'd5, 3'd2},
    {32'h0000_00E0, 1'b0, 5'd6, 3'd2},
    {32'h0000_00E0, 1'b0, 5'd7, 3'd2},
    {32'h0000_00E0, 1'b0, 5'd5, 3'd2},
    {32'h0000_0080, 1'b0, 5'd7, 3'd2},
    {32'h0000_0000, 1'b1, 5'd0, 3'd0},
    {32'h0000_0060, 1'b0, 5'd5, 3'd2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic insert(input int ch, input int lvl, input int pcr, input int mcr,
                        input bit minr, input bit exp_err, input string req);
    @(negedge clk);
    ins_valid    = 1'b1;
    ins_chan     = 5'(ch);
    ins_level    = 3'(lvl);
    ins_pcr_int  = 6'(pcr);
    ins_mcr_int  = 6'(mcr);
    ins_min_rate = minr;
    @(negedge clk);
    ins_valid = 1'b0;
    check(ins_err == exp_err, req, int'(ins_err), int'(exp_err));
  endtask

  task automatic slot(input logic [31:0] pend, input bit e_idle, input int e_ch,
                      input int e_lvl, input string req);
    @(negedge clk);
    cell_pend = pend;
    slot_tick = 1'b1;
    @(negedge clk);
    slot_tick = 1'b0;
    check(grant_valid == 1'b1, {req, " valid"}, int'(grant_valid), 1);
    check(grant_idle == e_idle, {req, " idle"}, int'(grant_idle), int'(e_idle));
    check(int'(grant_chan) == e_ch, {req, " chan"}, int'(grant_chan), e_ch);
    check(int'(grant_level) == e_lvl, {req, " level"}, int'(grant_level), e_lvl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ins_valid = 1'b0; ins_chan = '0; ins_level = '0;
    ins_pcr_int = '0; ins_mcr_int = '0; ins_min_rate = 1'b0;
    max_delay = 6'd2; cell_pend = '0; slot_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(grant_valid == 0, "R1 grant_valid", int'(grant_valid), 0);
    check(grant_idle == 0, "R1 grant_idle", int'(grant_idle), 0);
    check(ins_err == 0, "R1 ins_err", int'(ins_err), 0);
    slot(32'hFFFF_FFFF, 1'b1, 0, 0, "R1 empty tables idle");

    // R4 no grant without tick, pulse is one cycle
    repeat (3) begin
      @(negedge clk);
      check(grant_valid == 0, "R4 no tick", int'(grant_valid), 0);
    end

    // R2 inserts
    insert(3, 0, 1, 1, 1'b0, 1'b0, "R2 ch3");
    insert(5, 2, 1, 1, 1'b0, 1'b0, "R2 ch5");
    insert(6, 2, 1, 1, 1'b0, 1'b0, "R2 ch6");
    insert(7, 2, 1, 1, 1'b0, 1'b0, "R2 ch7");

    // R5 R6 R7 R8 vector walk
    for (int i = 0; i < 9; i++) begin
      slot(VECS[i][40:9], VECS[i][8], int'(VECS[i][7:3]), int'(VECS[i][2:0]),
           "R5 R6 R7 R8 vector");
    end
    @(negedge clk);
    check(grant_valid == 0, "R4 pulse ends", int'(grant_valid), 0);

    // R9 pacing interval 3
    insert(10, 1, 3, 3, 1'b0, 1'b0, "R2 ch10");
    slot(32'h0000_0400, 1'b0, 10, 1, "R9 first");
    slot(32'h0000_0400, 1'b1, 0, 0, "R9 gap1");
    slot(32'h0000_0400, 1'b1, 0, 0, "R9 gap2");
    slot(32'h0000_0400, 1'b0, 10, 1, "R9 again");

    // R10 R11 delay above threshold switches to minimum rate
    insert(12, 3, 1, 4, 1'b1, 1'b0, "R2 ch12");
    insert(13, 1, 1, 1, 1'b0, 1'b0, "R2 ch13");
    repeat (3) slot(32'h0000_3000, 1'b0, 13, 1, "R10 wait");
    slot(32'h0000_1000, 1'b0, 12, 3, "R11 late grant");
    repeat (3) slot(32'h0000_1000, 1'b1, 0, 0, "R11 mcr gap");
    slot(32'h0000_1000, 1'b0, 12, 3, "R11 after mcr gap");
    slot(32'h0000_1000, 1'b0, 12, 3, "R11 back to pcr");

    // R11 delay equal to threshold keeps peak rate
    repeat (2) slot(32'h0000_3000, 1'b0, 13, 1, "R10 wait2");
    slot(32'h0000_1000, 1'b0, 12, 3, "R11 at threshold");
    slot(32'h0000_1000, 1'b0, 12, 3, "R11 threshold pcr");

    // R11 unflagged channel ignores delay
    insert(14, 4, 1, 5, 1'b0, 1'b0, "R2 ch14");
    repeat (3) slot(32'h0000_6000, 1'b0, 13, 1, "R10 wait3");
    slot(32'h0000_4000, 1'b0, 14, 4, "R11 unflagged");
    slot(32'h0000_4000, 1'b0, 14, 4, "R11 unflagged pcr");

    // R3 duplicate rejected, channel stays in level 0
    insert(3, 5, 1, 1, 1'b0, 1'b1, "R3 duplicate");
    slot(32'h0000_0008, 1'b0, 3, 0, "R3 dup unchanged");

    // R3 full level
    for (int c = 16; c < 32; c++) insert(c, 7, 1, 1, 1'b0, 1'b0, "R2 fill level 7");
    insert(0, 7, 1, 1, 1'b0, 1'b1, "R3 full level");
    @(negedge clk);
    check(ins_err == 0, "R3 err one cycle", int'(ins_err), 0);
    slot(32'h0000_0001, 1'b1, 0, 0, "R3 rejected not member");
    slot(32'h8000_0000, 1'b0, 31, 7, "R2 full level serves");
    insert(0, 6, 1, 1, 1'b0, 1'b0, "R2 reinsert other level");
    slot(32'h0000_0001, 1'b0, 0, 6, "R2 reinserted");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule